// File: doc/BRIEF.md
# ALU Operation Decoder

This block turns a two-bit operation class, handed over by the main instruction decoder, and the six-bit function field of the current instruction into the four-bit control code that selects the ALU function. It is purely combinational and sits between the main decoder and the ALU of a single-cycle datapath. The result is valid in the same cycle that its inputs change.

Memory-access instructions and add-immediate always need an address-style addition, and a compare-and-branch always needs a subtraction so that the ALU zero flag signals equality. For these classes the function field is ignored. Only the register-to-register class looks at the function field, and any function value outside the supported five falls back to the addition code. The spare class value falls back to addition as well, so every input combination has a defined output.

Top module: `alu_op_decoder`

## Requirements
- R1: With class 2'b00 (memory access or add-immediate) the output is the add code 4'b0010 for every function value.
- R2: With class 2'b01 (branch) the output is the subtract code 4'b0110 for every function value.
- R3: With class 2'b10 (register op) and function 6'b100000 the output is 4'b0010 (add).
- R4: With class 2'b10 and function 6'b100010 the output is 4'b0110 (subtract).
- R5: With class 2'b10 and function 6'b100100 the output is 4'b0000 (bitwise AND).
- R6: With class 2'b10 and function 6'b100101 the output is 4'b0001 (bitwise OR).
- R7: With class 2'b10 and function 6'b101010 the output is 4'b0111 (set-on-less-than).
- R8: With class 2'b10 and any other function value the output is the add code 4'b0010.
- R9: With the spare class 2'b11 the output is the add code 4'b0010 for every function value.
- R10: The output is always one of 4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111 and follows an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of the instruction |
| alu_ctrl | output | 4 | ALU function select code |

## Verification
The bench uses the default package widths (two-bit class, six-bit function, four-bit code), which keep the whole input space at 256 combinations, so every class is driven with every function value rather than a sample. That exhaustive sweep reaches each of the five supported function codes, every unsupported one including values one bit away from a supported code, and the forced classes under all function values. A final step changes the inputs between clock edges to show the output needs no clock.

// File: rtl/alu_dec_pkg.sv
// Package: alu_dec_pkg
// Shared widths, class encoding, ALU codes and the table of supported
// register-op function values for the ALU operation decoder.
// Assumes a four-bit ALU code and a six-bit function field.
package alu_dec_pkg;

    localparam int CLASS_W = 2;
    localparam int FUNCT_W = 6;
    localparam int CTRL_W  = 4;
    localparam int NUM_OPS = 5;

    typedef enum logic [CLASS_W-1:0] {
        CLS_MEM    = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_REG    = 2'b10,
        CLS_SPARE  = 2'b11
    } op_class_e;

    typedef enum logic [CTRL_W-1:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_code_e;

    // Function value of table entry idx.
    function automatic logic [FUNCT_W-1:0] op_funct(input int idx);
        logic [FUNCT_W-1:0] f;
        case (idx)
            0:       f = 6'b100000;
            1:       f = 6'b100010;
            2:       f = 6'b100100;
            3:       f = 6'b100101;
            default: f = 6'b101010;
        endcase
        return f;
    endfunction

    // ALU code of table entry idx.
    function automatic alu_code_e op_code(input int idx);
        alu_code_e c;
        case (idx)
            0:       c = ALU_ADD;
            1:       c = ALU_SUB;
            2:       c = ALU_AND;
            3:       c = ALU_OR;
            default: c = ALU_SLT;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_funct_match.sv
// Module: alu_funct_match
// Compares the function field with every supported entry of the package
// table and raises one hit line per matching entry.
// Assumes the table entries are distinct, so at most one line is high.
module alu_funct_match
    import alu_dec_pkg::*;
#(
    parameter int N_OPS = NUM_OPS
) (
    input  logic [FUNCT_W-1:0] funct,
    output logic [N_OPS-1:0]   hit
);

    // One exact comparator per table entry.
    for (genvar k = 0; k < N_OPS; k++) begin : g_cmp
        assign hit[k] = (funct == op_funct(k));
    end

    // Distinct table entries never match together.
    always_comb begin
        p_single_hit_r10: assert ($onehot0(hit))
            else $error("p_single_hit_r10: more than one function match");
    end

endmodule

// File: rtl/alu_code_select.sv
// Module: alu_code_select
// Turns the hit lines into the register-op ALU code; with no hit the
// add code is produced.
// Assumes at most one hit line is high.
module alu_code_select
    import alu_dec_pkg::*;
#(
    parameter int N_OPS = NUM_OPS
) (
    input  logic [N_OPS-1:0] hit,
    output alu_code_e        reg_code
);

    // Priority-free pick of the matching entry's code, add by default.
    always_comb begin
        reg_code = ALU_ADD;
        for (int k = 0; k < N_OPS; k++) begin
            if (hit[k]) reg_code = op_code(k);
        end
    end

endmodule

// File: rtl/alu_class_mux.sv
// Module: alu_class_mux
// Chooses between forced codes and the decoded register-op code by class.
// Assumes the register-op code is already resolved by alu_code_select.
module alu_class_mux
    import alu_dec_pkg::*;
(
    input  op_class_e cls,
    input  alu_code_e reg_code,
    output alu_code_e code
);

    // Class selection: only register ops use the decoded code.
    always_comb begin
        unique case (cls)
            CLS_MEM:    code = ALU_ADD;
            CLS_BRANCH: code = ALU_SUB;
            CLS_REG:    code = reg_code;
            default:    code = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/alu_op_decoder.sv
// Module: alu_op_decoder (top)
// Combinational ALU control decoder: forced add for memory/immediate,
// forced subtract for branch, function decode for register ops, add for
// unsupported function values and for the spare class.
// Assumes inputs are stable within the cycle they are consumed.
module alu_op_decoder
    import alu_dec_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNCT_W-1:0] funct,
    output logic [CTRL_W-1:0]  alu_ctrl
);

    logic [NUM_OPS-1:0] hit;
    alu_code_e          reg_code;
    alu_code_e          code;

    alu_funct_match #(.N_OPS(NUM_OPS)) u_match (
        .funct (funct),
        .hit   (hit)
    );

    alu_code_select #(.N_OPS(NUM_OPS)) u_select (
        .hit      (hit),
        .reg_code (reg_code)
    );

    alu_class_mux u_mux (
        .cls      (op_class_e'(op_class)),
        .reg_code (reg_code),
        .code     (code)
    );

    assign alu_ctrl = code;

    // Port-level checks of the class and function decode.
    always_comb begin
        if (op_class == 2'b00)
            p_mem_add_r1: assert (alu_ctrl == 4'b0010)
                else $error("p_mem_add_r1: memory class not add");
        if (op_class == 2'b01)
            p_branch_sub_r2: assert (alu_ctrl == 4'b0110)
                else $error("p_branch_sub_r2: branch class not subtract");
        if (op_class == 2'b10 && hit[0])
            p_reg_add_r3: assert (alu_ctrl == 4'b0010)
                else $error("p_reg_add_r3: add function wrong");
        if (op_class == 2'b10 && hit[1])
            p_reg_sub_r4: assert (alu_ctrl == 4'b0110)
                else $error("p_reg_sub_r4: sub function wrong");
        if (op_class == 2'b10 && hit[2])
            p_reg_and_r5: assert (alu_ctrl == 4'b0000)
                else $error("p_reg_and_r5: and function wrong");
        if (op_class == 2'b10 && hit[3])
            p_reg_or_r6: assert (alu_ctrl == 4'b0001)
                else $error("p_reg_or_r6: or function wrong");
        if (op_class == 2'b10 && hit[4])
            p_reg_slt_r7: assert (alu_ctrl == 4'b0111)
                else $error("p_reg_slt_r7: slt function wrong");
        if (op_class == 2'b10 && hit == '0)
            p_reg_unknown_r8: assert (alu_ctrl == 4'b0010)
                else $error("p_reg_unknown_r8: unknown function not add");
        if (op_class == 2'b11)
            p_spare_add_r9: assert (alu_ctrl == 4'b0010)
                else $error("p_spare_add_r9: spare class not add");
        p_legal_code_r10: assert (alu_ctrl inside {4'b0000, 4'b0001, 4'b0010,
                                                   4'b0110, 4'b0111})
            else $error("p_legal_code_r10: illegal ALU code");
    end

endmodule

// File: tb/tb_alu_op_decoder.sv
module tb_alu_op_decoder;

    typedef struct {
        logic [1:0] cls;
        logic [5:0] fn;
        logic [3:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_class = '0;
    logic [5:0] funct = '0;
    logic [3:0] alu_ctrl;

    int    checks = 0;
    int    errors = 0;
    bit    drv_done = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    alu_op_decoder dut (
        .op_class (op_class),
        .funct    (funct),
        .alu_ctrl (alu_ctrl)
    );

    // Reference model written from the requirements.
    function automatic item_t model(input logic [1:0] c, input logic [5:0] f);
        item_t it;
        it.cls = c;
        it.fn  = f;
        case (c)
            2'b00: begin it.exp = 4'b0010; it.tag = "R1"; end
            2'b01: begin it.exp = 4'b0110; it.tag = "R2"; end
            2'b11: begin it.exp = 4'b0010; it.tag = "R9"; end
            default: begin
                case (f)
                    6'b100000: begin it.exp = 4'b0010; it.tag = "R3"; end
                    6'b100010: begin it.exp = 4'b0110; it.tag = "R4"; end
                    6'b100100: begin it.exp = 4'b0000; it.tag = "R5"; end
                    6'b100101: begin it.exp = 4'b0001; it.tag = "R6"; end
                    6'b101010: begin it.exp = 4'b0111; it.tag = "R7"; end
                    default:   begin it.exp = 4'b0010; it.tag = "R8"; end
                endcase
            end
        endcase
        return it;
    endfunction

    function automatic bit legal(input logic [3:0] v);
        return v inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111};
    endfunction

    // Driver: apply one stimulus at the falling edge and queue its expectation.
    task automatic drive(input logic [1:0] c, input logic [5:0] f);
        @(negedge clk);
        op_class = c;
        funct    = f;
        sb_q.push_back(model(c, f));
    endtask

    // Monitor: sample after each rising edge and compare with the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (alu_ctrl !== it.exp) begin
                    errors++;
                    $display("FAIL %s class=%b funct=%b got %b exp %b",
                             it.tag, it.cls, it.fn, alu_ctrl, it.exp);
                end
                checks++;
                if (!legal(alu_ctrl)) begin
                    errors++;
                    $display("FAIL R10 class=%b funct=%b got %b exp legal code",
                             it.cls, it.fn, alu_ctrl);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Exhaustive sweep: R1, R2, R3-R8 and R9 across all function values.
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 64; f++) begin
                drive(2'(c), 6'(f));
            end
        end
        // Between-edge change: output follows without a clock (R10).
        @(posedge clk);
        #2;
        op_class = 2'b10;
        funct    = 6'b100100;
        #1;
        checks++;
        if (alu_ctrl !== 4'b0000) begin
            errors++;
            $display("FAIL R10 no-clock update got %b exp 0000", alu_ctrl);
        end
        funct = 6'b101010;
        #1;
        checks++;
        if (alu_ctrl !== 4'b0111) begin
            errors++;
            $display("FAIL R10 no-clock update got %b exp 0111", alu_ctrl);
        end
        op_class = 2'b01;
        #1;
        checks++;
        if (alu_ctrl !== 4'b0110) begin
            errors++;
            $display("FAIL R2 no-clock update got %b exp 0110", alu_ctrl);
        end
        drv_done = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R10 scoreboard left %0d exp 0", sb_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule